// File: doc/BRIEF.md
# Auto-Increment Address Register with Start-Address Reload

This block tracks the byte address used for successive accesses to a 128-byte array. An address command loads a start address together with an access length: byte, word (2 bytes) or page (4 bytes). The block stores that start address twice. One copy is the working address, which moves forward after each completed access. The other is a shadow copy, which keeps the start address of the most recent address command.

The working address advances by the active access length and wraps around at the top of the array. After a word or page access it therefore points at the next word or page. A reload command copies the shadow copy back into the working address. A controller can then read a string it has just modified from its first byte, without keeping the start address itself. The array access itself happens outside this block.

The active length is held in a small state machine with three states:

| State | Stride | Entered when |
|---|---|---|
| `ST_BYTE` | 1 | reset, or a load with a byte or reserved length code |
| `ST_WORD` | 2 | a load with the word length code |
| `ST_PAGE` | 4 | a load with the page length code |

- The transitions `T_LOAD_BYTE`, `T_LOAD_WORD` and `T_LOAD_PAGE` happen on a load. Each goes from any state to the state matching the length code.
- Without a load, the state holds through `T_HOLD`. Reload and advance leave it unchanged.

The register update picks one of four operations each cycle. The priority is `OP_LOAD`, then `OP_RELOAD`, then `OP_STEP`, then `OP_HOLD`.

Top module: `addr_seq_reg`

## Requirements
- R1: After reset the working address is 0, the shadow copy is 0, and the active length is byte. An advance straight after reset gives address 1.
- R2: A load stores its address (aligned per R4/R5) into both the working address and the shadow copy. The new working address appears at the output one cycle after the load.
- R3: In byte mode each advance adds 1 to the working address. The change appears one cycle after the advance.
- R4: A load with length code 1 (word) clears address bit 0 before storing it. In word mode each advance adds 2.
- R5: A load with length code 2 (page) clears address bits 1:0 before storing it. In page mode each advance adds 4.
- R6: The working address wraps modulo 128. From 127 in byte mode, 126 in word mode or 124 in page mode, one advance gives 0.
- R7: A reload sets the working address to the shadow copy. It leaves the shadow copy unchanged, so repeated reloads always return the same start address.
- R8: When load and advance are both asserted in a cycle, the load wins and the advance is ignored.
- R9: When reload and advance are both asserted in a cycle (with no load), the reload wins and the advance is ignored.
- R10: Length code 3 is treated as a byte access: no alignment, and a stride of 1.
- R11: A reload keeps the active length, so advances after a reload use the stride of the last load.
- R12: When load and reload are both asserted in a cycle, the load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Address command: store the address and length |
| load_addr_i | input | 7 | Start address carried with the load |
| load_len_i | input | 2 | Access length: 0 byte, 1 word, 2 page, 3 treated as byte |
| advance_i | input | 1 | One access completed; step the working address |
| reload_i | input | 1 | Restore the working address from the shadow copy |
| cur_addr_o | output | 7 | Current working address |

## Verification
The bench builds the block with its default parameters:

- a 7-bit address;
- a word size of 2 and a page size of 4 bytes;
- alignment on load enabled.

With these values the wrap at the top of the 128-byte array is reached in a single advance from a high loaded address, and the alignment of odd word and page addresses can be seen directly. A reference model in the bench follows the load, reload and advance priorities. It is exercised with simultaneous commands, repeated reloads and every length code, including the reserved one.

// File: rtl/addr_seq_pkg.sv
package addr_seq_pkg;

    typedef enum logic [1:0] {
        LEN_BYTE = 2'd0,
        LEN_WORD = 2'd1,
        LEN_PAGE = 2'd2,
        LEN_RSVD = 2'd3
    } len_code_e;

    typedef enum logic [1:0] {
        ST_BYTE = 2'd0,
        ST_WORD = 2'd1,
        ST_PAGE = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_LOAD   = 2'd1,
        OP_RELOAD = 2'd2,
        OP_STEP   = 2'd3
    } op_e;

endpackage

// File: rtl/addr_seq_fsm.sv
module addr_seq_fsm
    import addr_seq_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int WORD_LOG2 = 1,
    parameter int PAGE_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  len_code_e         load_len_i,
    output mode_e             mode_o,
    output logic [ADDR_W-1:0] stride_o
);

    localparam logic [ADDR_W-1:0] STRIDE_BYTE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STRIDE_WORD = ADDR_W'(1) << WORD_LOG2;
    localparam logic [ADDR_W-1:0] STRIDE_PAGE = ADDR_W'(1) << PAGE_LOG2;

    mode_e state_q;
    mode_e state_d;

    // Next-state logic: only a load changes the active length.
    always_comb begin
        state_d = state_q;
        if (load_i) begin
            unique case (load_len_i)
                LEN_WORD: state_d = ST_WORD;
                LEN_PAGE: state_d = ST_PAGE;
                default:  state_d = ST_BYTE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_BYTE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs: the stride that belongs to the current state.
    always_comb begin
        unique case (state_q)
            ST_WORD: stride_o = STRIDE_WORD;
            ST_PAGE: stride_o = STRIDE_PAGE;
            default: stride_o = STRIDE_BYTE;
        endcase
    end

    assign mode_o = state_q;

endmodule

// File: rtl/addr_seq_align.sv
module addr_seq_align
    import addr_seq_pkg::*;
#(
    parameter int ADDR_W        = 7,
    parameter int WORD_LOG2     = 1,
    parameter int PAGE_LOG2     = 2,
    parameter bit ALIGN_ON_LOAD = 1'b1
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  len_code_e         len_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam logic [ADDR_W-1:0] WORD_MASK = (ADDR_W'(1) << WORD_LOG2) - ADDR_W'(1);
    localparam logic [ADDR_W-1:0] PAGE_MASK = (ADDR_W'(1) << PAGE_LOG2) - ADDR_W'(1);

    generate
        if (ALIGN_ON_LOAD) begin : g_align
            logic [ADDR_W-1:0] low_mask;

            // Pick which low bits to clear for the requested length.
            always_comb begin
                unique case (len_i)
                    LEN_WORD: low_mask = WORD_MASK;
                    LEN_PAGE: low_mask = PAGE_MASK;
                    default:  low_mask = '0;
                endcase
            end

            assign addr_o = addr_i & ~low_mask;
        end else begin : g_pass
            assign addr_o = addr_i;
        end
    endgenerate

endmodule

// File: rtl/addr_seq_regs.sv
module addr_seq_regs
    import addr_seq_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic              reload_i,
    input  logic              advance_i,
    input  logic [ADDR_W-1:0] stride_i,
    output logic [ADDR_W-1:0] cur_o,
    output logic [ADDR_W-1:0] start_o
);

    op_e               op;
    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] start_q;

    // Priority: load, then reload, then step, then hold.
    always_comb begin
        if (load_i) begin
            op = OP_LOAD;
        end else if (reload_i) begin
            op = OP_RELOAD;
        end else if (advance_i) begin
            op = OP_STEP;
        end else begin
            op = OP_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q   <= '0;
            start_q <= '0;
        end else begin
            unique case (op)
                OP_LOAD: begin
                    cur_q   <= load_addr_i;
                    start_q <= load_addr_i;
                end
                OP_RELOAD: cur_q <= start_q;
                // Natural width overflow gives the modulo-array wrap.
                OP_STEP:   cur_q <= cur_q + stride_i;
                default:   cur_q <= cur_q;
            endcase
        end
    end

    assign cur_o   = cur_q;
    assign start_o = start_q;

endmodule

// File: rtl/addr_seq_reg.sv
module addr_seq_reg
    import addr_seq_pkg::*;
#(
    parameter int ADDR_W        = 7,
    parameter int WORD_LOG2     = 1,
    parameter int PAGE_LOG2     = 2,
    parameter bit ALIGN_ON_LOAD = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic [1:0]        load_len_i,
    input  logic              advance_i,
    input  logic              reload_i,
    output logic [ADDR_W-1:0] cur_addr_o
);

    len_code_e         len_code;
    mode_e             mode_w;
    logic [ADDR_W-1:0] stride_w;
    logic [ADDR_W-1:0] aligned_w;
    logic [ADDR_W-1:0] start_w;

    assign len_code = len_code_e'(load_len_i);

    addr_seq_fsm #(
        .ADDR_W    (ADDR_W),
        .WORD_LOG2 (WORD_LOG2),
        .PAGE_LOG2 (PAGE_LOG2)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .load_len_i (len_code),
        .mode_o     (mode_w),
        .stride_o   (stride_w)
    );

    addr_seq_align #(
        .ADDR_W        (ADDR_W),
        .WORD_LOG2     (WORD_LOG2),
        .PAGE_LOG2     (PAGE_LOG2),
        .ALIGN_ON_LOAD (ALIGN_ON_LOAD)
    ) u_align (
        .addr_i (load_addr_i),
        .len_i  (len_code),
        .addr_o (aligned_w)
    );

    addr_seq_regs #(
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .load_addr_i (aligned_w),
        .reload_i    (reload_i),
        .advance_i   (advance_i),
        .stride_i    (stride_w),
        .cur_o       (cur_addr_o),
        .start_o     (start_w)
    );

endmodule

// File: rtl/addr_seq_chk.sv
module addr_seq_chk
    import addr_seq_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int WORD_LOG2 = 1,
    parameter int PAGE_LOG2 = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_i,
    input logic [ADDR_W-1:0] load_addr_i,
    input logic [1:0]        load_len_i,
    input logic              advance_i,
    input logic              reload_i,
    input logic [ADDR_W-1:0] cur_addr_o,
    input mode_e             mode_i,
    input logic [ADDR_W-1:0] start_i
);

    localparam logic [ADDR_W-1:0] WMASK = (ADDR_W'(1) << WORD_LOG2) - ADDR_W'(1);
    localparam logic [ADDR_W-1:0] PMASK = (ADDR_W'(1) << PAGE_LOG2) - ADDR_W'(1);

    p_load_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && (load_len_i == 2'd0 || load_len_i == 2'd3)) |=> (cur_addr_o == $past(load_addr_i)));

    p_byte_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && !load_i && !reload_i && mode_i == ST_BYTE)
        |=> (cur_addr_o == ADDR_W'($past(cur_addr_o) + ADDR_W'(1))));

    p_word_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == ST_WORD) |-> ((cur_addr_o & WMASK) == '0));

    p_page_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == ST_PAGE) |-> ((cur_addr_o & PMASK) == '0));

    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_i && !load_i) |=> (cur_addr_o == $past(start_i) && $stable(start_i)));

    p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && advance_i && load_len_i == 2'd0) |=> (cur_addr_o == $past(load_addr_i)));

    p_reload_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_i && !load_i) |=> $stable(mode_i));

endmodule

bind addr_seq_reg addr_seq_chk #(
    .ADDR_W    (ADDR_W),
    .WORD_LOG2 (WORD_LOG2),
    .PAGE_LOG2 (PAGE_LOG2)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .load_addr_i (load_addr_i),
    .load_len_i  (load_len_i),
    .advance_i   (advance_i),
    .reload_i    (reload_i),
    .cur_addr_o  (cur_addr_o),
    .mode_i      (mode_w),
    .start_i     (start_w)
);

// File: tb/addr_seq_reg_test.sv
module addr_seq_reg_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_i = 1'b0;
    logic [6:0] load_addr_i = '0;
    logic [1:0] load_len_i = '0;
    logic       advance_i = 1'b0;
    logic       reload_i = 1'b0;
    logic [6:0] cur_addr_o;

    int n_checks = 0;
    int n_fail = 0;

    // Reference model state.
    logic [6:0] m_cur = '0;
    logic [6:0] m_start = '0;
    int         m_len = 0;

    always #10 clk = ~clk;

    addr_seq_reg uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .load_addr_i (load_addr_i),
        .load_len_i  (load_len_i),
        .advance_i   (advance_i),
        .reload_i    (reload_i),
        .cur_addr_o  (cur_addr_o)
    );

    function automatic logic [6:0] m_align(logic [6:0] a, int len);
        if (len == 1) return a & 7'h7E;
        if (len == 2) return a & 7'h7C;
        return a;
    endfunction

    function automatic logic [6:0] m_stride(int len);
        if (len == 1) return 7'd2;
        if (len == 2) return 7'd4;
        return 7'd1;
    endfunction

    task automatic check(string req, logic [6:0] exp);
        n_checks++;
        if (cur_addr_o !== exp) begin
            n_fail++;
            $display("FAIL %s: cur_addr_o=%0d expected %0d", req, cur_addr_o, exp);
        end
    endtask

    // Drive one cycle of commands at a falling edge, update the model,
    // then compare at the next falling edge.
    task automatic step(string req, logic ld, logic [6:0] a, logic [1:0] len,
                        logic adv, logic rl);
        load_i      = ld;
        load_addr_i = a;
        load_len_i  = len;
        advance_i   = adv;
        reload_i    = rl;
        if (ld) begin
            m_len   = (len == 2'd1) ? 1 : (len == 2'd2) ? 2 : 0;
            m_cur   = m_align(a, m_len);
            m_start = m_cur;
        end else if (rl) begin
            m_cur = m_start;
        end else if (adv) begin
            m_cur = m_cur + m_stride(m_len);
        end
        @(negedge clk);
        load_i    = 1'b0;
        advance_i = 1'b0;
        reload_i  = 1'b0;
        check(req, m_cur);
    endtask

    task automatic t_reset_r1();
        check("R1", 7'd0);
        step("R1", 0, 0, 0, 1, 0);
    endtask

    task automatic t_byte_r3();
        step("R2", 1, 7'd10, 2'd0, 0, 0);
        step("R3", 0, 0, 0, 1, 0);
        step("R3", 0, 0, 0, 1, 0);
        step("R3", 0, 0, 0, 0, 0);
        step("R3", 0, 0, 0, 1, 0);
    endtask

    task automatic t_word_r4();
        step("R4", 1, 7'd21, 2'd1, 0, 0);
        step("R4", 0, 0, 0, 1, 0);
        step("R4", 0, 0, 0, 1, 0);
    endtask

    task automatic t_page_r5();
        step("R5", 1, 7'd55, 2'd2, 0, 0);
        step("R5", 0, 0, 0, 1, 0);
        step("R5", 0, 0, 0, 1, 0);
    endtask

    task automatic t_wrap_r6();
        step("R6", 1, 7'd127, 2'd0, 0, 0);
        step("R6", 0, 0, 0, 1, 0);
        step("R6", 1, 7'd127, 2'd1, 0, 0);
        step("R6", 0, 0, 0, 1, 0);
        step("R6", 1, 7'd125, 2'd2, 0, 0);
        step("R6", 0, 0, 0, 1, 0);
    endtask

    task automatic t_reload_r7();
        step("R7", 1, 7'd40, 2'd1, 0, 0);
        step("R7", 0, 0, 0, 1, 0);
        step("R7", 0, 0, 0, 1, 0);
        step("R7", 0, 0, 0, 0, 1);
        step("R11", 0, 0, 0, 1, 0);
        step("R11", 0, 0, 0, 1, 0);
        step("R7", 0, 0, 0, 0, 1);
    endtask

    task automatic t_priority_r8();
        step("R8", 0, 0, 0, 1, 0);
        step("R8", 1, 7'd90, 2'd0, 1, 0);
        step("R9", 0, 0, 0, 1, 0);
        step("R9", 0, 0, 0, 1, 1);
        step("R12", 1, 7'd3, 2'd2, 0, 1);
        step("R12", 0, 0, 0, 1, 0);
        step("R12", 0, 0, 0, 0, 1);
    endtask

    task automatic t_rsvd_r10();
        step("R10", 1, 7'd33, 2'd3, 0, 0);
        step("R10", 0, 0, 0, 1, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r1();
        t_byte_r3();
        t_word_r4();
        t_page_r5();
        t_wrap_r6();
        t_reload_r7();
        t_priority_r8();
        t_rsvd_r10();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule